// File: doc/BRIEF.md
# Interleaved Three-Phase Complementary PWM Generator

This block produces the gate-drive signals for a three-phase interleaved synchronous buck stage. A single master counter runs from zero to the programmed period minus one. Each of the three phases derives its own position from that counter, shifted by one third and two thirds of the period. Every phase drives a high-side and low-side switch as a complementary pair, with a programmable guard interval between them so that the two switches are never on together.

One duty value, one period value and one dead-time value are shared by all phases. The control loop can write them at any time. They are held in shadow registers and become active only at the next period boundary. The block pulses a strobe once every two periods, which the converter uses to launch a conversion and run the control law.

Each phase has its own overcurrent input. An asserted fault forces both switches of that phase off and latches. A fault-clear input releases the latch once the fault has gone away.

Top module: `pwm3_interleave`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, all of `hs_out`, `ls_out` and `ctl_strobe` are 0.
- R2: The master counter counts 0 to P-1 and then wraps, where P is the active period (default 200). Each phase's output pattern therefore repeats every P clocks.
- R3: Outputs are registered and follow the phase position pc of the previous cycle. For 0 < duty < P, `hs_out[k]` is 1 exactly when dead <= pc < duty, and `ls_out[k]` is 1 exactly when pc >= duty+dead. `hs_out[k]` and `ls_out[k]` are never 1 together.
- R4: Phase k uses pc = (count + off_k) mod P, with off_0 = 0, off_1 = floor(P/3) and off_2 = floor(2P/3). Bit index k of each output vector is phase k.
- R5: A duty of 0 holds `hs_out[k]` at 0 and `ls_out[k]` at 1. A duty >= P holds `hs_out[k]` at 1 and `ls_out[k]` at 0. No dead time applies in either case.
- R6: A write with `period_wr`, `duty_wr` or `dead_wr` is stored in a shadow register. It takes effect only from the first cycle of the next period, after the counter wraps.
- R7: `ctl_strobe` is a one-clock pulse that rises at the clock edge ending the 2nd, 4th, 6th, ... period after reset.
- R8: When `fault_in[k]` is 1, `hs_out[k]` and `ls_out[k]` are 0 from the next clock edge. The other phases are unaffected.
- R9: After a fault, phase k stays off until `fault_clr` is sampled high while `fault_in[k]` is 0. A clear given while the fault is still present is ignored.
- R10: A period value below 4 is loaded as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_in | input | CNT_W | New master period, in clocks |
| period_wr | input | 1 | Store `period_in` in the shadow register |
| duty_in | input | CNT_W | New shared duty value, in clocks |
| duty_wr | input | 1 | Store `duty_in` in the shadow register |
| dead_in | input | DEAD_W | New dead-time value, in clocks |
| dead_wr | input | 1 | Store `dead_in` in the shadow register |
| fault_in | input | 3 | Overcurrent indication, one bit per phase |
| fault_clr | input | 1 | Release latched faults whose input is inactive |
| hs_out | output | 3 | High-side drive, one bit per phase |
| ls_out | output | 3 | Low-side drive, one bit per phase |
| ctl_strobe | output | 1 | Control-loop / conversion trigger pulse |

## Verification
The shared waveform is run at the default 200-clock period and at a short 30-clock period. This separates the correct one-third and two-thirds offsets from offsets that are rounded or taken from the wrong register. Duty values of zero, exactly the period, below the dead time and in between exercise the clamps and separate them from the normal edge placement. A duty write placed mid-period shows whether the shadow register is honoured or the new value leaks in early. A fault sequence on a single phase includes a premature clear, a release, and then a proper clear. It distinguishes latching from pass-through gating and confirms that the neighbouring phases keep running.

// File: rtl/pwm3_pkg.sv
// Shared constants for the interleaved three-phase PWM generator.
// Assumes nothing beyond a single clock domain.
package pwm3_pkg;
    localparam int NUM_PHASES = 3;
    localparam int MIN_PERIOD = 4;
    localparam int PHASE_DIV  = 3;
endpackage

// File: rtl/pwm3_timebase.sv
// Master timebase: shadow and active copies of period, duty and dead time,
// the master counter, the wrap flag and the every-second-period strobe.
// Assumes the active period is at least pwm3_pkg::MIN_PERIOD.
module pwm3_timebase #(
    parameter int CNT_W    = 16,
    parameter int DEAD_W   = 8,
    parameter int PER_DEF  = 200,
    parameter int DUTY_DEF = 100,
    parameter int DEAD_DEF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_in,
    input  logic              period_wr,
    input  logic [CNT_W-1:0]  duty_in,
    input  logic              duty_wr,
    input  logic [DEAD_W-1:0] dead_in,
    input  logic              dead_wr,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  per_act,
    output logic [CNT_W-1:0]  duty_act,
    output logic [DEAD_W-1:0] dead_act,
    output logic              strobe
);
    import pwm3_pkg::*;

    localparam logic [CNT_W-1:0]  PER_MIN = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0]  PER_RST = CNT_W'(PER_DEF);
    localparam logic [CNT_W-1:0]  DUT_RST = CNT_W'(DUTY_DEF);
    localparam logic [DEAD_W-1:0] DED_RST = DEAD_W'(DEAD_DEF);

    logic [CNT_W-1:0]  per_sh;
    logic [CNT_W-1:0]  duty_sh;
    logic [DEAD_W-1:0] dead_sh;
    logic [CNT_W-1:0]  per_clamped;
    logic              wrap;
    logic              half;

    // Last count of the active period.
    assign wrap        = (cnt == per_act - CNT_W'(1));
    // Raise too-short periods to the minimum.
    assign per_clamped = (per_sh < PER_MIN) ? PER_MIN : per_sh;

    // Capture writes from the control loop into the shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh  <= PER_RST;
            duty_sh <= DUT_RST;
            dead_sh <= DED_RST;
        end else begin
            if (period_wr) per_sh  <= period_in;
            if (duty_wr)   duty_sh <= duty_in;
            if (dead_wr)   dead_sh <= dead_in;
        end
    end

    // Advance the master counter; at wrap load the shadows into the active set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            per_act  <= (PER_RST < PER_MIN) ? PER_MIN : PER_RST;
            duty_act <= DUT_RST;
            dead_act <= DED_RST;
        end else if (wrap) begin
            cnt      <= '0;
            per_act  <= per_clamped;
            duty_act <= duty_sh;
            dead_act <= dead_sh;
        end else begin
            cnt      <= cnt + CNT_W'(1);
        end
    end

    // Pulse the strobe on every second wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half   <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= wrap & half;
            if (wrap) half <= ~half;
        end
    end
endmodule

// File: rtl/pwm3_fault_latch.sv
// Per-phase overcurrent latch. A fault sets the latch. Clear releases it
// only while the fault input is inactive. The output is the live input
// OR'ed with the latch.
// Assumes fault_in is already synchronous to clk.
module pwm3_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic fault_clr,
    output logic fault_act
);
    logic latched;

    // Set on fault, release on clear when the fault is gone.
    always_ff @(posedge clk) begin
        if (!rst_n)         latched <= 1'b0;
        else if (fault_in)  latched <= 1'b1;
        else if (fault_clr) latched <= 1'b0;
    end

    // Block the phase while the fault is present or remembered.
    assign fault_act = fault_in | latched;
endmodule

// File: rtl/pwm3_phase_gen.sv
// One phase: shifts the master count by an offset, modulo the period.
// Places the high-side window and the low-side window with dead time
// between them, and registers the gated pair.
// Assumes cnt < per and off < per.
module pwm3_phase_gen #(
    parameter int CNT_W  = 16,
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  off,
    input  logic [CNT_W-1:0]  per,
    input  logic [CNT_W-1:0]  duty,
    input  logic [DEAD_W-1:0] dead,
    input  logic              fault_act,
    output logic              hs,
    output logic              ls
);
    logic [CNT_W:0]   pc_sum;
    logic [CNT_W-1:0] pc;
    logic [CNT_W:0]   lo_start;
    logic [CNT_W-1:0] dead_ext;
    logic             raw_h;
    logic             raw_l;

    assign dead_ext = CNT_W'(dead);
    assign pc_sum   = {1'b0, cnt} + {1'b0, off};
    assign lo_start = {1'b0, duty} + {1'b0, dead_ext};

    // Fold the shifted count back into the period.
    always_comb begin
        if (pc_sum >= {1'b0, per}) pc = CNT_W'(pc_sum - {1'b0, per});
        else                       pc = pc_sum[CNT_W-1:0];
    end

    // Choose the switch states for this phase position.
    always_comb begin
        if (duty == '0) begin
            raw_h = 1'b0;
            raw_l = 1'b1;
        end else if (duty >= per) begin
            raw_h = 1'b1;
            raw_l = 1'b0;
        end else begin
            raw_h = (pc >= dead_ext) && (pc < duty);
            raw_l = ({1'b0, pc} >= lo_start);
        end
    end

    // Register the pair, forced off while the phase is faulted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs <= 1'b0;
            ls <= 1'b0;
        end else begin
            hs <= raw_h & ~fault_act;
            ls <= raw_l & ~fault_act;
        end
    end
endmodule

// File: rtl/pwm3_interleave.sv
// Top of the interleaved three-phase complementary PWM generator.
// Builds the per-phase offsets (k*P/3, rounded down) from the active period
// and instantiates one fault latch and one phase generator per phase.
// Assumes all inputs are synchronous to clk.
module pwm3_interleave #(
    parameter int CNT_W    = 16,
    parameter int DEAD_W   = 8,
    parameter int PER_DEF  = 200,
    parameter int DUTY_DEF = 100,
    parameter int DEAD_DEF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_in,
    input  logic              period_wr,
    input  logic [CNT_W-1:0]  duty_in,
    input  logic              duty_wr,
    input  logic [DEAD_W-1:0] dead_in,
    input  logic              dead_wr,
    input  logic [2:0]        fault_in,
    input  logic              fault_clr,
    output logic [2:0]        hs_out,
    output logic [2:0]        ls_out,
    output logic              ctl_strobe
);
    import pwm3_pkg::*;

    localparam int PROD_W = CNT_W + 2;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  per_act;
    logic [CNT_W-1:0]  duty_act;
    logic [DEAD_W-1:0] dead_act;

    pwm3_timebase #(
        .CNT_W(CNT_W), .DEAD_W(DEAD_W), .PER_DEF(PER_DEF),
        .DUTY_DEF(DUTY_DEF), .DEAD_DEF(DEAD_DEF)
    ) u_tb (
        .clk(clk), .rst_n(rst_n),
        .period_in(period_in), .period_wr(period_wr),
        .duty_in(duty_in), .duty_wr(duty_wr),
        .dead_in(dead_in), .dead_wr(dead_wr),
        .cnt(cnt), .per_act(per_act), .duty_act(duty_act),
        .dead_act(dead_act), .strobe(ctl_strobe)
    );

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
        logic [PROD_W-1:0] prod;
        logic [CNT_W-1:0]  off;
        logic              fact;

        // Offset of phase k: k*P/PHASE_DIV, rounded down.
        assign prod = PROD_W'(k) * {2'b00, per_act};
        assign off  = CNT_W'(prod / PROD_W'(PHASE_DIV));

        pwm3_fault_latch u_flt (
            .clk(clk), .rst_n(rst_n),
            .fault_in(fault_in[k]), .fault_clr(fault_clr),
            .fault_act(fact)
        );

        pwm3_phase_gen #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_gen (
            .clk(clk), .rst_n(rst_n),
            .cnt(cnt), .off(off), .per(per_act),
            .duty(duty_act), .dead(dead_act),
            .fault_act(fact),
            .hs(hs_out[k]), .ls(ls_out[k])
        );
    end
endmodule

// File: rtl/pwm3_interleave_chk.sv
// Property checker for pwm3_interleave, attached with bind.
// Observes only the ports of the top module.
module pwm3_interleave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] fault_in,
    input logic [2:0] hs_out,
    input logic [2:0] ls_out,
    input logic       ctl_strobe
);
    logic was_rst;

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) was_rst <= ~rst_n;

    // R1: first cycle out of reset is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (hs_out == 3'b000 && ls_out == 3'b000 && !ctl_strobe));

    // R3: the pair of any phase is never on together.
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_out & ls_out) == 3'b000);

    // R7: strobe lasts a single clock.
    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_strobe |=> !ctl_strobe);

    // R8: a faulted phase is off at the next edge.
    assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_in) |=> (((hs_out | ls_out) & $past(fault_in)) == 3'b000));
endmodule

bind pwm3_interleave pwm3_interleave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
    .hs_out(hs_out), .ls_out(ls_out), .ctl_strobe(ctl_strobe)
);

// File: tb/tb_pwm3_interleave.sv
// Scoreboard bench: a reference process pushes expected output items each
// clock, and a monitor pops and compares them on the falling edge.
module tb_pwm3_interleave;
    localparam int CNT_W  = 16;
    localparam int DEAD_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  period_in = '0;
    logic              period_wr = 1'b0;
    logic [CNT_W-1:0]  duty_in = '0;
    logic              duty_wr = 1'b0;
    logic [DEAD_W-1:0] dead_in = '0;
    logic              dead_wr = 1'b0;
    logic [2:0]        fault_in = 3'b000;
    logic              fault_clr = 1'b0;
    logic [2:0]        hs_out;
    logic [2:0]        ls_out;
    logic              ctl_strobe;

    int    n_checks = 0;
    int    n_errors = 0;
    string scen_tag = "R1";

    always #4 clk = ~clk;

    pwm3_interleave dut (
        .clk(clk), .rst_n(rst_n),
        .period_in(period_in), .period_wr(period_wr),
        .duty_in(duty_in), .duty_wr(duty_wr),
        .dead_in(dead_in), .dead_wr(dead_wr),
        .fault_in(fault_in), .fault_clr(fault_clr),
        .hs_out(hs_out), .ls_out(ls_out), .ctl_strobe(ctl_strobe)
    );

    // Expected-item queues
    logic [2:0] q_hs[$];
    logic [2:0] q_ls[$];
    logic       q_stb[$];
    string      q_tag[$];

    // Reference state built from the requirements
    int m_cnt, m_per, m_duty, m_dead, s_per, s_duty, s_dead;
    bit m_half;
    bit [2:0] m_lat;

    always @(posedge clk) begin
        logic [2:0] eh, el;
        logic es;
        if (!rst_n) begin
            m_cnt = 0; m_per = 200; m_duty = 100; m_dead = 10;
            s_per = 200; s_duty = 100; s_dead = 10;
            m_half = 0; m_lat = 3'b000;
            eh = 3'b000; el = 3'b000; es = 1'b0;
            q_tag.push_back("R1");
        end else begin
            for (int k = 0; k < 3; k++) begin
                int off, pc;
                bit rh, rl;
                off = (k * m_per) / 3;
                pc = (m_cnt + off) % m_per;
                if (m_duty == 0)           begin rh = 0; rl = 1; end
                else if (m_duty >= m_per)  begin rh = 1; rl = 0; end
                else begin
                    rh = (pc >= m_dead) && (pc < m_duty);
                    rl = (pc >= m_duty + m_dead);
                end
                eh[k] = rh && !(fault_in[k] || m_lat[k]);
                el[k] = rl && !(fault_in[k] || m_lat[k]);
                if (fault_in[k])   m_lat[k] = 1'b1;
                else if (fault_clr) m_lat[k] = 1'b0;
            end
            es = (m_cnt == m_per - 1) && m_half;
            if (m_cnt == m_per - 1) begin
                m_half = !m_half;
                m_cnt  = 0;
                m_per  = (s_per < 4) ? 4 : s_per;
                m_duty = s_duty;
                m_dead = s_dead;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (period_wr) s_per  = int'(period_in);
            if (duty_wr)   s_duty = int'(duty_in);
            if (dead_wr)   s_dead = int'(dead_in);
            q_tag.push_back(scen_tag);
        end
        q_hs.push_back(eh);
        q_ls.push_back(el);
        q_stb.push_back(es);
    end

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        if (q_hs.size() > 0) begin
            logic [2:0] xh, xl;
            logic xs;
            string t;
            xh = q_hs.pop_front(); xl = q_ls.pop_front();
            xs = q_stb.pop_front(); t = q_tag.pop_front();
            n_checks++;
            if (hs_out !== xh) begin
                n_errors++;
                $display("FAIL %s hs_out actual %b expected %b at %0t", t, hs_out, xh, $time);
            end
            n_checks++;
            if (ls_out !== xl) begin
                n_errors++;
                $display("FAIL %s ls_out actual %b expected %b at %0t", t, ls_out, xl, $time);
            end
            n_checks++;
            if (ctl_strobe !== xs) begin
                n_errors++;
                $display("FAIL R7 ctl_strobe actual %b expected %b at %0t", ctl_strobe, xs, $time);
            end
            n_checks++;
            if ((hs_out & ls_out) !== 3'b000) begin
                n_errors++;
                $display("FAIL R3 overlap hs %b ls %b expected no common bit", hs_out, ls_out);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_period(input int v);
        period_in = CNT_W'(v); period_wr = 1'b1;
        @(negedge clk); period_wr = 1'b0;
    endtask

    task automatic set_duty(input int v);
        duty_in = CNT_W'(v); duty_wr = 1'b1;
        @(negedge clk); duty_wr = 1'b0;
    endtask

    task automatic set_dead(input int v);
        dead_in = DEAD_W'(v); dead_wr = 1'b1;
        @(negedge clk); dead_wr = 1'b0;
    endtask

    bit done = 0;

    initial begin
        scen_tag = "R1";
        run(4);
        rst_n = 1'b1;
        // Default period, offsets and dead-time placement
        scen_tag = "R2/R3/R4";
        run(430);
        // Mid-period duty write must wait for the wrap
        scen_tag = "R6";
        run(50);
        set_duty(60);
        run(260);
        // Short period with new duty and dead time
        scen_tag = "R2/R4/R6";
        set_period(30); set_duty(12); set_dead(3);
        run(130);
        // Duty clamps
        scen_tag = "R5";
        set_duty(0);  run(70);
        set_duty(30); run(70);
        set_duty(45); run(70);
        // Duty below dead time
        scen_tag = "R3";
        set_duty(2); set_dead(5);
        run(70);
        set_duty(12); set_dead(3);
        run(70);
        // Fault on phase 1 only
        scen_tag = "R8";
        fault_in = 3'b010;
        run(40);
        scen_tag = "R9";
        fault_clr = 1'b1; run(3); fault_clr = 1'b0;
        run(10);
        fault_in = 3'b000;
        run(40);
        fault_clr = 1'b1; run(1); fault_clr = 1'b0;
        run(70);
        // Phase 0 and 2 together
        scen_tag = "R8/R9";
        fault_in = 3'b101; run(20); fault_in = 3'b000;
        fault_clr = 1'b1; run(1); fault_clr = 1'b0;
        run(40);
        // Period below minimum, then an odd period
        scen_tag = "R10";
        set_period(2); run(40);
        scen_tag = "R4";
        set_period(7); run(50);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule